// File: doc/BRIEF.md
# Vector-Placement and Interrupt-Gating Control Register

This block is an 8-bit control register on a simple CPU register bus. It holds two things. The first is a select bit that tells the vector fetch logic whether the interrupt table starts at the beginning of program ROM or at the beginning of the boot section. The second is a mode bit that lets only the SPI-related interrupt sources through. The upper five bits are plain read/write storage. Other logic decodes them.

The select bit is guarded by a timed unlock. Software first writes a 1 to the change-enable bit. That opens a short window. A second write inside the window carries the new select value with change-enable written as 0. While the unlock is in progress, the block raises its own interrupt-block output and forces the gated request vector to zero. This does not touch any global interrupt-enable flag. If the select write happens, the block holds until the CPU retires one more instruction. If it does not happen, the block lifts when the window closes.

Top module: `vecsel_irq_ctrl`

## Requirements
- R1: After reset the read value is 0x00, `vec_boot` is 0 and `irq_block` is 0.
- R2: Bits 7:2 of `bus_rdata` return the value last written to bits 7:2. Bit 2 is the SPI-only mode bit.
- R3: A write with bit 0 = 1 sets change-enable. From the next cycle, read bit 0 is 1 and `irq_block` is 1.
- R4: If no select write arrives, change-enable reads 1 for exactly WINDOW (default 4) cycles after it is set. After that it reads 0, and `irq_block` drops with it.
- R5: A write with bit 0 = 0 while change-enable reads 1 loads bit 1 into the vector select (`vec_boot`, read bit 1). It also clears change-enable. This holds up to and including the last cycle of the window.
- R6: A write to bit 1 has no effect on the vector select in two cases: when change-enable reads 0, or when the same write has bit 0 = 1.
- R7: After a select write, `irq_block` stays 1 until the first `retire_strobe` sampled on a later clock edge. It is 0 from the following cycle. A strobe on the edge of the select write itself does not release it.
- R8: With SPI-only mode on and no block active, `irq_gated` is `irq_req` AND SPI_MASK. The default SPI_MASK is 0x0038 (request bits 3, 4 and 5).
- R9: While `irq_block` is 1, `irq_gated` is all zeros. With no block and SPI-only off, `irq_gated` equals `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| retire_strobe | input | 1 | One pulse per retired CPU instruction |
| irq_req | input | NUM_IRQ | Raw interrupt requests |
| bus_rdata | output | 8 | Current register value |
| irq_gated | output | NUM_IRQ | Requests after masking |
| vec_boot | output | 1 | 1 = vectors at boot section, 0 = ROM start |
| irq_block | output | 1 | Unlock sequence is blocking interrupts |

## Verification
Two kinds of internal fault are visible at the ports.

A wrong window counter shows on read bit 0 and on `irq_block`. It appears in the cycle after the fourth window cycle. It also shows as a select write on the window's last cycle being dropped, which `vec_boot` reveals one cycle later.

A wrong release condition leaves `irq_gated` at zero, or releases it too soon. This is seen one cycle after the retire strobe.

A mask fault appears on `irq_gated` in the same cycle the request is applied. The bench uses a table of control and request patterns for this. Directed sequences cover the window edges and the timing of the retire strobe.

// File: rtl/icr_pkg.sv
package icr_pkg;
   localparam int REG_W    = 8;
   localparam int CE_POS   = 0;
   localparam int VSEL_POS = 1;
   localparam int SPI_POS  = 2;
   localparam int AUX_W    = REG_W - SPI_POS - 1;

   typedef struct packed {
      logic [AUX_W-1:0] aux;
      logic             spi_only;
      logic             vsel;
      logic             ce;
   } ctrl_reg_t;
endpackage

// File: rtl/icr_store.sv
module icr_store
   import icr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AUX_W-1:0] wr_aux,
   input  logic             wr_spi,
   output logic [AUX_W-1:0] aux_o,
   output logic             spi_only_o
);
   logic [AUX_W-1:0] aux_q;
   logic             spi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux_q <= '0;
         spi_q <= 1'b0;
      end else if (wr_en) begin
         aux_q <= wr_aux;
         spi_q <= wr_spi;
      end
   end

   assign aux_o      = aux_q;
   assign spi_only_o = spi_q;
endmodule

// File: rtl/icr_unlock.sv
module icr_unlock #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_ce,
   input  logic wr_vsel,
   input  logic retire,
   output logic ce_o,
   output logic vsel_o,
   output logic block_o
);
   localparam int AGE_W = $clog2(WINDOW + 1) + 1;

   if (WINDOW < 1) begin : g_bad_window
      $error("icr_unlock: WINDOW must be at least 1");
   end

   logic ce_q, vsel_q, hold_q;
   logic open_wr, sel_wr, expire;

   assign open_wr = wr_en & wr_ce;
   assign sel_wr  = wr_en & ce_q & ~wr_ce;

   if (WINDOW == 1) begin : g_win_single
      assign expire = ce_q;
   end else begin : g_win_count
      localparam int CNT_W = $clog2(WINDOW);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                     cnt_q <= '0;
         else if (open_wr)               cnt_q <= CNT_W'(WINDOW - 1);
         else if (ce_q && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign expire = ce_q && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         vsel_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (open_wr)     ce_q <= 1'b1;
         else if (sel_wr) ce_q <= 1'b0;
         else if (expire) ce_q <= 1'b0;

         if (sel_wr) vsel_q <= wr_vsel;

         if (sel_wr)      hold_q <= 1'b1;
         else if (retire) hold_q <= 1'b0;
      end
   end

   assign ce_o    = ce_q;
   assign vsel_o  = vsel_q;
   assign block_o = ce_q | hold_q;

   logic [AGE_W-1:0] ce_age;
   always_ff @(posedge clk) begin
      if (!rst_n)       ce_age <= '0;
      else if (open_wr) ce_age <= '0;
      else if (ce_q)    ce_age <= ce_age + 1'b1;
      else              ce_age <= '0;
   end

   // R3
   ce_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_wr |=> (ce_q && block_o));

   // R4
   ce_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_q |-> (ce_age < AGE_W'(WINDOW)));

   // R6
   vsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsel_q) |-> $past(wr_en && ce_q && !wr_ce));

   // R7
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_o && !ce_q && retire && !wr_en) |=> !block_o);
endmodule

// File: rtl/icr_irq_gate.sv
module icr_irq_gate #(
   parameter int               NUM_IRQ  = 16,
   parameter logic [NUM_IRQ-1:0] SPI_MASK = 16'h0038
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               block,
   input  logic               spi_only,
   input  logic [NUM_IRQ-1:0] req,
   output logic [NUM_IRQ-1:0] gated
);
   if (NUM_IRQ < 1) begin : g_bad_width
      $error("icr_irq_gate: NUM_IRQ must be at least 1");
   end
   if (SPI_MASK == '0) begin : g_bad_mask
      $error("icr_irq_gate: SPI_MASK selects no source");
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      logic pass;
      assign pass     = !block && (!spi_only || SPI_MASK[i]);
      assign gated[i] = req[i] & pass;
   end

   // R9
   block_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block |-> (gated == '0));

   // R8
   spi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_only && !block) |-> (gated == (req & SPI_MASK)));
endmodule

// File: rtl/vecsel_irq_ctrl.sv
module vecsel_irq_ctrl
   import icr_pkg::*;
#(
   parameter int                 NUM_IRQ  = 16,
   parameter logic [NUM_IRQ-1:0] SPI_MASK = 16'h0038,
   parameter int                 WINDOW   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [REG_W-1:0]   bus_wdata,
   input  logic               retire_strobe,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic [REG_W-1:0]   bus_rdata,
   output logic [NUM_IRQ-1:0] irq_gated,
   output logic               vec_boot,
   output logic               irq_block
);
   ctrl_reg_t wr_view, rd_view;
   logic      ce_w, vsel_w, spi_w;
   logic [AUX_W-1:0] aux_w;

   assign wr_view = ctrl_reg_t'(bus_wdata);

   icr_store u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_we),
      .wr_aux     (wr_view.aux),
      .wr_spi     (wr_view.spi_only),
      .aux_o      (aux_w),
      .spi_only_o (spi_w)
   );

   icr_unlock #(.WINDOW(WINDOW)) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .wr_ce   (wr_view.ce),
      .wr_vsel (wr_view.vsel),
      .retire  (retire_strobe),
      .ce_o    (ce_w),
      .vsel_o  (vsel_w),
      .block_o (irq_block)
   );

   icr_irq_gate #(.NUM_IRQ(NUM_IRQ), .SPI_MASK(SPI_MASK)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .block    (irq_block),
      .spi_only (spi_w),
      .req      (irq_req),
      .gated    (irq_gated)
   );

   always_comb begin
      rd_view.aux      = aux_w;
      rd_view.spi_only = spi_w;
      rd_view.vsel     = vsel_w;
      rd_view.ce       = ce_w;
   end

   assign bus_rdata = rd_view;
   assign vec_boot  = vsel_w;
endmodule

// File: tb/vecsel_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vecsel_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n, bus_we, retire_strobe;
   logic [7:0]  bus_wdata, bus_rdata;
   logic [15:0] irq_req, irq_gated;
   logic        vec_boot, irq_block;
   int          total = 0;
   int          fails = 0;

   always #2.5 clk = ~clk;

   vecsel_irq_ctrl u_vecsel_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .retire_strobe(retire_strobe), .irq_req(irq_req), .bus_rdata(bus_rdata),
      .irq_gated(irq_gated), .vec_boot(vec_boot), .irq_block(irq_block)
   );

   // {ctrl write, request, expected gated, expected readback}
   localparam logic [47:0] VEC [6] = '{
      {8'h00, 16'hFFFF, 16'hFFFF, 8'h00},
      {8'h04, 16'hFFFF, 16'h0038, 8'h04},
      {8'h04, 16'h00C7, 16'h0000, 8'h04},
      {8'hFC, 16'h1234, 16'h0030, 8'hFC},
      {8'hA8, 16'h5A5A, 16'h5A5A, 8'hA8},
      {8'h06, 16'h003F, 16'h0038, 8'h04}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      bus_we = 1'b1;
      bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_retire();
      retire_strobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      retire_strobe = 1'b0;
   endtask

   initial begin
      #1_000_000;
      fails++;
      total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_wdata = '0; retire_strobe = 1'b0;
      irq_req = 16'hFFFF;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1
      chk(bus_rdata, 8'h00, "R1 rdata");
      chk(vec_boot, 1'b0, "R1 vec_boot");
      chk(irq_block, 1'b0, "R1 irq_block");
      chk(irq_gated, 16'hFFFF, "R9 pass-through");

      // R2 R8 R9 R6: table walk
      for (int k = 0; k < 6; k++) begin
         wr(VEC[k][47:40]);
         irq_req = VEC[k][39:24];
         #1;
         chk(irq_gated, VEC[k][23:8], "R8/R9 table gated");
         chk(bus_rdata, VEC[k][7:0], "R2/R6 table readback");
      end
      wr(8'h00);
      irq_req = 16'hFFFF;

      // R3 R4
      wr(8'h01);
      chk(bus_rdata, 8'h01, "R3 ce set");
      chk(irq_block, 1'b1, "R3 block");
      chk(irq_gated, 16'h0000, "R9 blocked");
      idle(3);
      chk(bus_rdata[0], 1'b1, "R4 ce last window cycle");
      idle(1);
      chk(bus_rdata, 8'h00, "R4 ce expired");
      chk(irq_block, 1'b0, "R4 block released");
      chk(irq_gated, 16'hFFFF, "R9 after expiry");

      // R6 same write
      wr(8'h03);
      chk(vec_boot, 1'b0, "R6 same write");
      chk(bus_rdata, 8'h01, "R6 same write readback");
      idle(4);
      // R6 after window
      wr(8'h01);
      idle(4);
      wr(8'h02);
      chk(vec_boot, 1'b0, "R6 late write");
      chk(irq_block, 1'b0, "R6 late block");

      // R5 R7
      wr(8'h01);
      wr(8'h02);
      chk(vec_boot, 1'b1, "R5 select");
      chk(bus_rdata, 8'h02, "R5 ce cleared");
      chk(irq_block, 1'b1, "R7 hold");
      idle(3);
      chk(irq_block, 1'b1, "R7 hold without retire");
      pulse_retire();
      chk(irq_block, 1'b0, "R7 release");
      chk(irq_gated, 16'hFFFF, "R9 after release");

      // R7 retire on the select edge is ignored
      wr(8'h01);
      retire_strobe = 1'b1;
      wr(8'h00);
      retire_strobe = 1'b0;
      chk(vec_boot, 1'b0, "R5 select back");
      chk(irq_block, 1'b1, "R7 same-edge retire");
      pulse_retire();
      chk(irq_block, 1'b0, "R7 later retire");

      // R5 last cycle of window
      wr(8'h01);
      idle(3);
      wr(8'h02);
      chk(vec_boot, 1'b1, "R5 last window cycle");
      pulse_retire();
      chk(irq_block, 1'b0, "R7 release 2");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule